// File: doc/BRIEF.md
# External Interrupt Line Controller

This block watches 23 asynchronous input lines and turns selected edges, or requests written by software, into latched pending flags. Each line has its own interrupt mask, event mask, rising-edge select and falling-edge select. A pending flag stays set until software clears it by writing a 1 to it. The block drives one combined interrupt output and one event-pulse output per line.

Each input passes through a chain of synchronising flops. It then reaches a two-state level tracker with the states LVL_LOW and LVL_HIGH. The transition RISE (LVL_LOW to LVL_HIGH) flags a rising edge for one cycle. The transition FALL (LVL_HIGH to LVL_LOW) flags a falling edge for one cycle. When the synchronised level does not differ from the state, the tracker holds its state and flags nothing.

The register port is a single-cycle write strobe with a byte address, plus a combinational read-data output. Each register holds one bit per line in bits 22:0. The word is selected by address bits 4:2, and a write lands only when bits 1:0 are zero.

Top module: `xline_ctl`

## Requirements
- R1: After reset, every register reads zero, `irq_out` is 0 and `evt_pulse` is all zero.
- R2: The register offsets are: 0x00 interrupt mask, 0x04 event mask, 0x08 rising select, 0x0C falling select, 0x10 software trigger, 0x14 pending. Mask and select registers read back the written bits 22:0. Bits 31:23 of every register read 0 and ignore writes. Any other offset reads 0.
- R3: Each line is synchronised by two flops. If bit i is set in the rising select, a rising edge on line i sets pending bit i. If bit i is set in the falling select, a falling edge sets it, and with both bits set either edge does. The bit becomes visible after the third rising clock edge that follows the input change.
- R4: A line with neither edge selected never sets its pending bit from its input.
- R5: Writing 1 to a software-trigger bit that holds 0 sets that bit and the matching pending bit. Writing 1 to a bit already at 1 has no effect, and writing 0 has no effect.
- R6: Writing 1 to a pending bit clears it and also clears the matching software-trigger bit. Writing 0 leaves both unchanged.
- R7: A write that changes bit i of the rising or falling select clears pending bit i. The software-trigger bit is left unchanged.
- R8: When a trigger and a clear hit the same line in the same cycle, the pending bit ends up set.
- R9: `irq_out` is the OR over all lines of pending AND interrupt mask.
- R10: When a line with its event-mask bit set is triggered, `evt_pulse[i]` is high for exactly one cycle. That cycle is the one in which the pending bit first reads set. A line whose event-mask bit is clear never pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_in | input | 23 | Asynchronous input lines |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq_out | output | 1 | Combined interrupt request |
| evt_pulse | output | 23 | Per-line single-cycle event pulses |

## Verification
The hardest case to reach is a hardware edge and a write-1-to-clear landing on the same line in the same cycle. The edge only becomes a trigger two flops after the pin changes. To hit that cycle, the bench raises a line configured for both edges and lets it latch. It then drops the line and asserts the clear write in the second cycle afterwards, so the write lands on the same edge that samples the falling trigger. A control clear issued later with a quiet line confirms that the bit still reads set only because of the coincidence.

// File: rtl/xline_pkg.sv
package xline_pkg;

    localparam int ADDR_W   = 5;
    localparam int IDX_W    = 3;
    localparam int NUM_REGS = 6;
    localparam int NUM_CFG  = 4;

    // Word index taken from address bits 4:2
    typedef enum logic [IDX_W-1:0] {
        REG_IMASK  = 3'd0,
        REG_EMASK  = 3'd1,
        REG_RISE   = 3'd2,
        REG_FALL   = 3'd3,
        REG_SWTRIG = 3'd4,
        REG_PEND   = 3'd5
    } reg_idx_t;

    // Level tracker states used for edge detection
    typedef enum logic {
        LVL_LOW  = 1'b0,
        LVL_HIGH = 1'b1
    } lvl_state_t;

endpackage

// File: rtl/xline_edge_det.sv
module xline_edge_det
    import xline_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise,
    output logic fall
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   synced;
    lvl_state_t             state_q;
    lvl_state_t             state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], din};
        end
    end

    assign synced = sync_q[SYNC_STAGES-1];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LVL_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and edge flags
    always_comb begin
        state_d = state_q;
        rise    = 1'b0;
        fall    = 1'b0;
        unique case (state_q)
            LVL_LOW: begin
                if (synced) begin
                    state_d = LVL_HIGH;
                    rise    = 1'b1;
                end
            end
            LVL_HIGH: begin
                if (!synced) begin
                    state_d = LVL_LOW;
                    fall    = 1'b1;
                end
            end
            default: state_d = LVL_LOW;
        endcase
    end

    AST_RISE_NOT_REPEATED: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);  // R3

    AST_FALL_NOT_REPEATED: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);  // R3

endmodule

// File: rtl/xline_cfg.sv
module xline_cfg
    import xline_pkg::*;
#(
    parameter int N_LINES = 23
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_CFG-1:0] cfg_wr,
    input  logic [N_LINES-1:0] wdata,
    output logic [N_LINES-1:0] imask,
    output logic [N_LINES-1:0] emask,
    output logic [N_LINES-1:0] rise_sel,
    output logic [N_LINES-1:0] fall_sel,
    output logic [N_LINES-1:0] sense_clr
);

    logic [N_LINES-1:0] cfg_q [NUM_CFG];

    for (genvar k = 0; k < NUM_CFG; k++) begin : g_cfg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cfg_q[k] <= '0;
            end else if (cfg_wr[k]) begin
                cfg_q[k] <= wdata;
            end
        end
    end

    assign imask    = cfg_q[REG_IMASK];
    assign emask    = cfg_q[REG_EMASK];
    assign rise_sel = cfg_q[REG_RISE];
    assign fall_sel = cfg_q[REG_FALL];

    // Lines whose edge selection is being altered by this write
    assign sense_clr = (cfg_wr[REG_RISE] ? (wdata ^ cfg_q[REG_RISE]) : '0)
                     | (cfg_wr[REG_FALL] ? (wdata ^ cfg_q[REG_FALL]) : '0);

    AST_SELECT_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr[REG_RISE] |=> (rise_sel == $past(wdata)));  // R2

endmodule

// File: rtl/xline_pend.sv
module xline_pend #(
    parameter int N_LINES = 23
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] hw_trig,
    input  logic               sw_wr,
    input  logic               w1c_wr,
    input  logic [N_LINES-1:0] wdata,
    input  logic [N_LINES-1:0] sense_clr,
    input  logic [N_LINES-1:0] emask,
    output logic [N_LINES-1:0] pend_q,
    output logic [N_LINES-1:0] sw_q,
    output logic [N_LINES-1:0] evt_q
);

    logic [N_LINES-1:0] sw_set;
    logic [N_LINES-1:0] w1c;
    logic [N_LINES-1:0] trig;
    logic [N_LINES-1:0] pend_d;
    logic [N_LINES-1:0] sw_d;

    always_comb begin
        sw_set = sw_wr  ? (wdata & ~sw_q) : '0;
        w1c    = w1c_wr ? wdata : '0;
        trig   = hw_trig | sw_set;
        // a trigger outranks both kinds of clear
        pend_d = trig | (pend_q & ~w1c & ~sense_clr);
        sw_d   = sw_set | (sw_q & ~w1c);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
            sw_q   <= '0;
            evt_q  <= '0;
        end else begin
            pend_q <= pend_d;
            sw_q   <= sw_d;
            evt_q  <= trig & emask;
        end
    end

    AST_TRIG_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_trig != '0) |=> ((pend_q & $past(hw_trig)) == $past(hw_trig)));  // R8

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (w1c_wr && ((wdata & ~hw_trig) != '0)) |=>
            ((pend_q & $past(wdata & ~hw_trig)) == '0));  // R6

    AST_SENSE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ((sense_clr & ~hw_trig) != '0) |=> ((pend_q & $past(sense_clr & ~hw_trig)) == '0));  // R7

    AST_SW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !w1c_wr |=> ((($past(sw_q)) & ~sw_q) == '0));  // R5

    AST_EVT_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_q & ~$past(emask)) == '0);  // R10

endmodule

// File: rtl/xline_ctl.sv
module xline_ctl
    import xline_pkg::*;
#(
    parameter int N_LINES     = 23,
    parameter int DATA_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] line_in,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               irq_out,
    output logic [N_LINES-1:0] evt_pulse
);

    localparam int PAD_W = DATA_W - N_LINES;

    logic                  aligned;
    logic [IDX_W-1:0]      widx;
    logic [NUM_REGS-1:0]   wr_strobe;
    logic [N_LINES-1:0]    wdata_l;
    logic [N_LINES-1:0]    imask, emask, rise_sel, fall_sel, sense_clr;
    logic [N_LINES-1:0]    rise_v, fall_v, hw_trig;
    logic [N_LINES-1:0]    pend_q, sw_q;
    logic [N_LINES-1:0]    rd_l;
    logic                  unused_hi;

    assign aligned   = (bus_addr[1:0] == 2'b00);
    assign widx      = bus_addr[ADDR_W-1:2];
    assign wdata_l   = bus_wdata[N_LINES-1:0];
    assign unused_hi = ^bus_wdata[DATA_W-1:N_LINES];

    for (genvar k = 0; k < NUM_REGS; k++) begin : g_dec
        assign wr_strobe[k] = bus_wr && aligned && (widx == IDX_W'(k));
    end

    xline_cfg #(.N_LINES(N_LINES)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_wr    (wr_strobe[NUM_CFG-1:0]),
        .wdata     (wdata_l),
        .imask     (imask),
        .emask     (emask),
        .rise_sel  (rise_sel),
        .fall_sel  (fall_sel),
        .sense_clr (sense_clr)
    );

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        xline_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_det (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (line_in[g]),
            .rise  (rise_v[g]),
            .fall  (fall_v[g])
        );
    end

    assign hw_trig = (rise_v & rise_sel) | (fall_v & fall_sel);

    xline_pend #(.N_LINES(N_LINES)) u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .hw_trig   (hw_trig),
        .sw_wr     (wr_strobe[REG_SWTRIG]),
        .w1c_wr    (wr_strobe[REG_PEND]),
        .wdata     (wdata_l),
        .sense_clr (sense_clr),
        .emask     (emask),
        .pend_q    (pend_q),
        .sw_q      (sw_q),
        .evt_q     (evt_pulse)
    );

    assign irq_out = |(pend_q & imask);

    always_comb begin
        rd_l = '0;
        if (aligned) begin
            unique case (widx)
                REG_IMASK:  rd_l = imask;
                REG_EMASK:  rd_l = emask;
                REG_RISE:   rd_l = rise_sel;
                REG_FALL:   rd_l = fall_sel;
                REG_SWTRIG: rd_l = sw_q;
                REG_PEND:   rd_l = pend_q;
                default:    rd_l = '0;
            endcase
        end
    end

    assign bus_rdata = {{PAD_W{1'b0}}, rd_l};

    AST_NO_SELECT_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr && ((rise_sel | fall_sel) == '0)) |=>
            ((pend_q & ~$past(pend_q)) == '0));  // R4

    AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q == '0) |-> !irq_out);  // R9

endmodule

// File: tb/xline_ctl_test.sv
module xline_ctl_test;

    localparam int NL = 23;
    localparam int NV = 35;
    localparam logic [1:0] OP_W = 2'd0;
    localparam logic [1:0] OP_R = 2'd1;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [NL-1:0]   line_in;
    logic            bus_wr;
    logic [4:0]      bus_addr;
    logic [31:0]     bus_wdata;
    logic [31:0]     bus_rdata;
    logic            irq_out;
    logic [NL-1:0]   evt_pulse;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    xline_ctl uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_in   (line_in),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_out   (irq_out),
        .evt_pulse (evt_pulse)
    );

    // {req[3:0], op[1:0], addr[4:0], wdata[31:0], expected[31:0]}
    localparam logic [74:0] VEC [NV] = '{
        {4'd2, OP_W, 5'h00, 32'hFFFF_FFFF, 32'h0},         // R2
        {4'd2, OP_R, 5'h00, 32'h0, 32'h007F_FFFF},         // R2 reserved bits
        {4'd2, OP_W, 5'h04, 32'h0000_0011, 32'h0},         // R2
        {4'd2, OP_R, 5'h04, 32'h0, 32'h0000_0011},         // R2
        {4'd2, OP_W, 5'h08, 32'h8000_0100, 32'h0},         // R2
        {4'd2, OP_R, 5'h08, 32'h0, 32'h0000_0100},         // R2
        {4'd2, OP_W, 5'h0C, 32'h0000_0200, 32'h0},         // R2
        {4'd2, OP_R, 5'h0C, 32'h0, 32'h0000_0200},         // R2
        {4'd2, OP_R, 5'h18, 32'h0, 32'h0},                 // R2 unknown offset
        {4'd5, OP_W, 5'h10, 32'h0000_0005, 32'h0},         // R5
        {4'd5, OP_R, 5'h14, 32'h0, 32'h0000_0005},         // R5
        {4'd5, OP_R, 5'h10, 32'h0, 32'h0000_0005},         // R5
        {4'd5, OP_W, 5'h10, 32'h0000_0004, 32'h0},         // R5 already set
        {4'd5, OP_R, 5'h14, 32'h0, 32'h0000_0005},         // R5
        {4'd6, OP_W, 5'h14, 32'h0000_0001, 32'h0},         // R6
        {4'd6, OP_R, 5'h14, 32'h0, 32'h0000_0004},         // R6
        {4'd6, OP_R, 5'h10, 32'h0, 32'h0000_0004},         // R6
        {4'd6, OP_W, 5'h14, 32'h0000_0000, 32'h0},         // R6 write zero
        {4'd6, OP_R, 5'h14, 32'h0, 32'h0000_0004},         // R6
        {4'd7, OP_W, 5'h08, 32'h0000_0104, 32'h0},         // R7 line 2 select change
        {4'd7, OP_R, 5'h14, 32'h0, 32'h0000_0000},         // R7
        {4'd7, OP_R, 5'h10, 32'h0, 32'h0000_0004},         // R7 trigger bit kept
        {4'd5, OP_W, 5'h10, 32'h0000_0004, 32'h0},         // R5 bit at 1, no effect
        {4'd5, OP_R, 5'h14, 32'h0, 32'h0000_0000},         // R5
        {4'd6, OP_W, 5'h14, 32'h0000_0004, 32'h0},         // R6
        {4'd6, OP_R, 5'h10, 32'h0, 32'h0000_0000},         // R6 trigger bit cleared
        {4'd5, OP_W, 5'h10, 32'h0000_0004, 32'h0},         // R5 re-arm
        {4'd5, OP_R, 5'h14, 32'h0, 32'h0000_0004},         // R5
        {4'd6, OP_W, 5'h14, 32'hFFFF_FFFF, 32'h0},         // R6
        {4'd6, OP_R, 5'h14, 32'h0, 32'h0000_0000},         // R6
        {4'd6, OP_R, 5'h10, 32'h0, 32'h0000_0000},         // R6
        {4'd1, OP_W, 5'h00, 32'h0, 32'h0},                 // cleanup
        {4'd1, OP_W, 5'h04, 32'h0, 32'h0},
        {4'd1, OP_W, 5'h08, 32'h0, 32'h0},
        {4'd1, OP_W, 5'h0C, 32'h0, 32'h0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_wr    = 1'b0;
        bus_wdata = '0;
    endtask

    task automatic rd_chk(input string tag, input logic [4:0] a, input logic [31:0] exp);
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n     = 1'b0;
        line_in   = '0;
        bus_wr    = 1'b0;
        bus_addr  = '0;
        bus_wdata = '0;
        wait_n(3);
        rst_n = 1'b1;
        wait_n(1);

        // R1 reset state
        for (int a = 0; a < 6; a++) begin
            rd_chk($sformatf("R1 reset reg %0d", a), 5'(a * 4), 32'h0);
        end
        chk("R1 irq after reset", {31'h0, irq_out}, 32'h0);
        chk("R1 evt after reset", {9'h0, evt_pulse}, 32'h0);

        // register table
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][70:69] == OP_W) begin
                wr(VEC[i][68:64], VEC[i][63:32]);
            end else begin
                rd_chk($sformatf("R%0d vector %0d", VEC[i][74:71], i),
                       VEC[i][68:64], VEC[i][31:0]);
            end
        end

        // R3 rising edge on line 3 with latency, R9 and R10 outputs
        wr(5'h08, 32'h0000_0008);
        wr(5'h04, 32'h0000_0008);
        wr(5'h00, 32'h0000_0008);
        line_in[3] = 1'b1;
        wait_n(2);
        rd_chk("R3 not yet visible", 5'h14, 32'h0);
        wait_n(1);
        rd_chk("R3 rise sets pending", 5'h14, 32'h0000_0008);
        chk("R10 event pulse high", {9'h0, evt_pulse}, 32'h0000_0008);
        chk("R9 irq with mask", {31'h0, irq_out}, 32'h1);
        wait_n(1);
        chk("R10 event pulse one cycle", {9'h0, evt_pulse}, 32'h0);
        wr(5'h14, 32'h0000_0008);
        rd_chk("R6 clear hw pending", 5'h14, 32'h0);
        chk("R9 irq drops", {31'h0, irq_out}, 32'h0);
        line_in[3] = 1'b0;
        wait_n(4);
        rd_chk("R3 fall ignored without select", 5'h14, 32'h0);

        // R3 falling-only on line 5
        wr(5'h0C, 32'h0000_0020);
        line_in[5] = 1'b1;
        wait_n(4);
        rd_chk("R3 rise ignored on fall-only line", 5'h14, 32'h0);
        line_in[5] = 1'b0;
        wait_n(3);
        rd_chk("R3 fall sets pending", 5'h14, 32'h0000_0020);
        chk("R10 no pulse when event masked", {9'h0, evt_pulse}, 32'h0);
        chk("R9 no irq when masked", {31'h0, irq_out}, 32'h0);
        wr(5'h14, 32'h0000_0020);

        // R4 line 7 has no edge selected
        line_in[7] = 1'b1;
        wait_n(4);
        line_in[7] = 1'b0;
        wait_n(4);
        rd_chk("R4 unselected line stays clear", 5'h14, 32'h0);

        // R8 falling trigger coincides with clear on line 9
        wr(5'h08, 32'h0000_0208);
        wr(5'h0C, 32'h0000_0220);
        line_in[9] = 1'b1;
        wait_n(3);
        rd_chk("R3 both-edge line rise", 5'h14, 32'h0000_0200);
        line_in[9] = 1'b0;
        @(negedge clk);
        @(negedge clk);
        bus_wr    = 1'b1;
        bus_addr  = 5'h14;
        bus_wdata = 32'h0000_0200;
        @(negedge clk);
        bus_wr    = 1'b0;
        bus_wdata = '0;
        rd_chk("R8 set wins over clear", 5'h14, 32'h0000_0200);
        wr(5'h14, 32'h0000_0200);
        rd_chk("R6 later clear works", 5'h14, 32'h0);

        // R5 software trigger with event and interrupt
        wr(5'h10, 32'h0000_0008);
        chk("R10 event from software trigger", {9'h0, evt_pulse}, 32'h0000_0008);
        chk("R9 irq from software trigger", {31'h0, irq_out}, 32'h1);
        wait_n(1);
        chk("R10 software event one cycle", {9'h0, evt_pulse}, 32'h0);
        rd_chk("R5 software pending", 5'h14, 32'h0000_0008);

        // R7 changing falling select of line 3 clears its pending bit
        wr(5'h0C, 32'h0000_0228);
        rd_chk("R7 select change clears", 5'h14, 32'h0);
        rd_chk("R7 trigger bit kept", 5'h10, 32'h0000_0008);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule